// File: doc/BRIEF.md
# DVMA Address Translator

This block sits between a bus-master DMA engine and system memory. It maps 32-bit device virtual addresses onto physical addresses through a flat translation table in memory. Software programs a control word, which holds the enable and the window size, and the table base address. The device then presents one virtual address at a time, together with a read/write flag. The block checks that the address falls inside the translation window and works out the table slot. It reads the 64-bit table entry over a simple memory read port, decodes it, and answers with either a physical address or a fault.

The translation window always ends at the top of the 32-bit space and grows downward as the 3-bit size code rises: code n gives a window of 8 MB << n. Pages are always 8 KB. A single cached entry, tagged by virtual page number, spares the table read on repeated accesses to one page. Any write to the control, base or flush register drops that cached entry.

Top module: `dvma_xlate`

## Requirements
- R1: Out of reset, `req_ready` is 1, `rsp_valid` is 0, `mem_req_valid` is 0 and the cached entry is empty.
- R2: With control bit 0 clear, every request ends in a fault and issues no table read.
- R3: Control bits 18:16 hold size code n. The window runs from 2^32 - 2^(23+n) up to 0xFFFFFFFF. An address below the window faults and issues no table read.
- R4: The table read address is {base bits 40:13, 13'b0} + ((va - window start) >> 13) * 8. Base register bits 12:0 and bits above 40 are ignored.
- R5: A table entry with bit 63 clear gives a fault. Every faulting response carries a physical address of 0.
- R6: A write request whose entry has bit 1 clear faults. A read of the same entry succeeds.
- R7: A successful translation returns {entry bits 40:13, va bits 12:0}.
- R8: A request to the page (va bits 31:13) of the last valid fetched entry issues no table read. Only one entry is held, so a different page evicts it.
- R9: A write to register address 0 (control), 1 (base) or 2 (flush) empties the cached entry. A write to address 3 has no effect.
- R10: A flush write that lands while a table read is outstanding keeps that entry out of the cache.
- R11: One request is served at a time. `req_ready` stays low from acceptance until the response handshake. `rsp_valid`, `rsp_fault` and `rsp_pa` hold steady until `rsp_ready`. A table read request holds its address until accepted.
- R12: Control bits 1 and 2 and entry bits 61, 60, 59 and 4 do not change any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 control, 1 base, 2 flush |
| cfg_wdata | input | CFG_DW | Register write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block idle, can accept a request |
| req_va | input | VA_W | Device virtual address |
| req_write | input | 1 | Request is a write |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_fault | output | 1 | Translation failed |
| rsp_pa | output | PA_W | Physical address, 0 on fault |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Table read request accepted |
| mem_req_addr | output | PA_W | Table entry address |
| mem_rsp_valid | input | 1 | Table read data valid |
| mem_rsp_data | input | ENT_W | Table entry |

## Verification
The bench builds the block with its default geometry: 32-bit virtual space, 41-bit physical space, 8 KB pages and a smallest window of 8 MB. It sweeps all eight size codes. For each code it probes the address just below the window, the first and last slots, invalid slots and read-only slots. The memory model derives every entry arithmetically from its address, so expected results come straight from the window formula. A read-ready line that toggles every cycle exercises the fetch handshake.

// File: rtl/dvma_pkg.sv
package dvma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_FETCH,
        ST_WAIT,
        ST_RESP
    } xl_state_e;

    localparam logic [1:0] CFG_CTRL  = 2'd0;
    localparam logic [1:0] CFG_BASE  = 2'd1;
    localparam logic [1:0] CFG_FLUSH = 2'd2;
endpackage

// File: rtl/dvma_cfg_regs.sv
module dvma_cfg_regs #(
    parameter int CFG_DW     = 64,
    parameter int PA_W       = 41,
    parameter int PAGE_SHIFT = 13,
    parameter int SIZE_W     = 3,
    parameter int SIZE_LSB   = 16,
    parameter int EN_BIT     = 0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [1:0]                 cfg_addr,
    input  logic [CFG_DW-1:0]          cfg_wdata,
    output logic                       xl_en,
    output logic [SIZE_W-1:0]          win_code,
    output logic [PA_W-PAGE_SHIFT-1:0] tbl_ppn,
    output logic                       inval
);
    import dvma_pkg::*;
    localparam int PPN_W = PA_W - PAGE_SHIFT;

    typedef struct packed {
        logic              en;
        logic [SIZE_W-1:0] code;
        logic [PPN_W-1:0]  ppn;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic unused_wdata;

    assign unused_wdata = ^cfg_wdata;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            case (cfg_addr)
                CFG_CTRL: begin
                    cfg_d.en   = cfg_wdata[EN_BIT];
                    cfg_d.code = cfg_wdata[SIZE_LSB +: SIZE_W];
                end
                CFG_BASE: cfg_d.ppn = cfg_wdata[PA_W-1:PAGE_SHIFT];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign xl_en    = cfg_q.en;
    assign win_code = cfg_q.code;
    assign tbl_ppn  = cfg_q.ppn;
    assign inval    = cfg_we && (cfg_addr == CFG_CTRL || cfg_addr == CFG_BASE ||
                                 cfg_addr == CFG_FLUSH);
endmodule

// File: rtl/dvma_window.sv
module dvma_window #(
    parameter int VA_W       = 32,
    parameter int PA_W       = 41,
    parameter int PAGE_SHIFT = 13,
    parameter int SIZE_W     = 3,
    parameter int MIN_WIN_LG = 23,
    parameter int ENT_LG     = 3
) (
    input  logic [SIZE_W-1:0]          win_code,
    input  logic [VA_W-1:0]            va,
    input  logic [PA_W-PAGE_SHIFT-1:0] tbl_ppn,
    output logic                       in_win,
    output logic [PA_W-1:0]            slot_addr
);
    localparam int VPN_W = VA_W - PAGE_SHIFT;

    logic [VA_W:0]     win_len;
    logic [VA_W:0]     win_lo;
    logic [VA_W-1:0]   off;
    logic [VPN_W-1:0]  slot;
    logic              unused_off;

    always_comb begin
        win_len   = {{VA_W{1'b0}}, 1'b1} << (MIN_WIN_LG + int'(win_code));
        win_lo    = {1'b1, {VA_W{1'b0}}} - win_len;
        in_win    = {1'b0, va} >= win_lo;
        off       = va - win_lo[VA_W-1:0];
        slot      = off[VA_W-1:PAGE_SHIFT];
        slot_addr = {tbl_ppn, {PAGE_SHIFT{1'b0}}} + PA_W'({slot, {ENT_LG{1'b0}}});
    end

    assign unused_off = ^off[PAGE_SHIFT-1:0];
endmodule

// File: rtl/dvma_entry_dec.sv
module dvma_entry_dec #(
    parameter int ENT_W      = 64,
    parameter int PA_W       = 41,
    parameter int PAGE_SHIFT = 13,
    parameter int V_BIT      = 63,
    parameter int W_BIT      = 1
) (
    input  logic [ENT_W-1:0]           ent,
    output logic                       ent_ok,
    output logic                       ent_wr,
    output logic [PA_W-PAGE_SHIFT-1:0] ent_ppn
);
    logic unused_ent;

    assign ent_ok     = ent[V_BIT];
    assign ent_wr     = ent[W_BIT];
    assign ent_ppn    = ent[PA_W-1:PAGE_SHIFT];
    assign unused_ent = ^ent;
endmodule

// File: rtl/dvma_xlate.sv
module dvma_xlate #(
    parameter int VA_W       = 32,
    parameter int PA_W       = 41,
    parameter int PAGE_SHIFT = 13,
    parameter int SIZE_W     = 3,
    parameter int MIN_WIN_LG = 23,
    parameter int ENT_W      = 64,
    parameter int CFG_DW     = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_va,
    input  logic              req_write,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_fault,
    output logic [PA_W-1:0]   rsp_pa,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ENT_W-1:0]  mem_rsp_data
);
    import dvma_pkg::*;
    localparam int VPN_W = VA_W - PAGE_SHIFT;
    localparam int PPN_W = PA_W - PAGE_SHIFT;

    typedef struct packed {
        xl_state_e         st;
        logic [VA_W-1:0]   va;
        logic              wr;
        logic [PA_W-1:0]   fa;
        logic              fault;
        logic [PA_W-1:0]   pa;
        logic              c_vld;
        logic [VPN_W-1:0]  c_vpn;
        logic [PPN_W-1:0]  c_ppn;
        logic              c_wr;
        logic              fill_ok;
    } xl_t;

    xl_t               xl_d, xl_q;
    logic              xl_en, inval, in_win, ent_ok, ent_wr, flt;
    logic [SIZE_W-1:0] win_code;
    logic [PPN_W-1:0]  tbl_ppn, ent_ppn;
    logic [PA_W-1:0]   slot_addr;
    logic [VPN_W-1:0]  vpn;

    dvma_cfg_regs #(
        .CFG_DW(CFG_DW), .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT), .SIZE_W(SIZE_W),
        .SIZE_LSB(16), .EN_BIT(0)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .xl_en(xl_en), .win_code(win_code),
        .tbl_ppn(tbl_ppn), .inval(inval)
    );

    dvma_window #(
        .VA_W(VA_W), .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT), .SIZE_W(SIZE_W),
        .MIN_WIN_LG(MIN_WIN_LG), .ENT_LG(3)
    ) u_win (
        .win_code(win_code), .va(xl_q.va), .tbl_ppn(tbl_ppn),
        .in_win(in_win), .slot_addr(slot_addr)
    );

    dvma_entry_dec #(
        .ENT_W(ENT_W), .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT), .V_BIT(63), .W_BIT(1)
    ) u_dec (
        .ent(mem_rsp_data), .ent_ok(ent_ok), .ent_wr(ent_wr), .ent_ppn(ent_ppn)
    );

    assign vpn = xl_q.va[VA_W-1:PAGE_SHIFT];

    always_comb begin
        xl_d = xl_q;
        flt  = 1'b0;
        case (xl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    xl_d.va = req_va;
                    xl_d.wr = req_write;
                    xl_d.st = ST_LOOK;
                end
            end
            ST_LOOK: begin
                xl_d.fa = slot_addr;
                if (!xl_en || !in_win) begin
                    xl_d.fault = 1'b1;
                    xl_d.pa    = '0;
                    xl_d.st    = ST_RESP;
                end else if (xl_q.c_vld && xl_q.c_vpn == vpn) begin
                    flt        = xl_q.wr && !xl_q.c_wr;
                    xl_d.fault = flt;
                    xl_d.pa    = flt ? '0 : {xl_q.c_ppn, xl_q.va[PAGE_SHIFT-1:0]};
                    xl_d.st    = ST_RESP;
                end else begin
                    xl_d.fill_ok = 1'b1;
                    xl_d.st      = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (mem_req_ready) xl_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    flt        = !ent_ok || (xl_q.wr && !ent_wr);
                    xl_d.fault = flt;
                    xl_d.pa    = flt ? '0 : {ent_ppn, xl_q.va[PAGE_SHIFT-1:0]};
                    if (ent_ok && xl_q.fill_ok) begin
                        xl_d.c_vld = 1'b1;
                        xl_d.c_vpn = vpn;
                        xl_d.c_ppn = ent_ppn;
                        xl_d.c_wr  = ent_wr;
                    end
                    xl_d.st = ST_RESP;
                end
            end
            ST_RESP: begin
                if (rsp_ready) xl_d.st = ST_IDLE;
            end
            default: xl_d.st = ST_IDLE;
        endcase
        if (inval) begin
            xl_d.c_vld   = 1'b0;
            xl_d.fill_ok = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) xl_q <= '0;
        else        xl_q <= xl_d;
    end

    assign req_ready     = (xl_q.st == ST_IDLE);
    assign rsp_valid     = (xl_q.st == ST_RESP);
    assign rsp_fault     = xl_q.fault;
    assign rsp_pa        = xl_q.pa;
    assign mem_req_valid = (xl_q.st == ST_FETCH);
    assign mem_req_addr  = xl_q.fa;
endmodule

// File: rtl/dvma_xlate_chk.sv
module dvma_xlate_chk #(
    parameter int VA_W       = 32,
    parameter int PA_W       = 41,
    parameter int PAGE_SHIFT = 13
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VA_W-1:0] req_va,
    input logic            rsp_valid,
    input logic            rsp_ready,
    input logic            rsp_fault,
    input logic [PA_W-1:0] rsp_pa,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [PA_W-1:0] mem_req_addr
);
    logic [VA_W-1:0] va_cap;

    always_ff @(posedge clk) begin
        if (!rst_n)                      va_cap <= '0;
        else if (req_valid && req_ready) va_cap <= req_va;
    end

    // R11
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R11
    accept_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R11
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_fault)));

    // R11
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R5
    fault_pa_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_pa == '0));

    // R7
    pa_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_pa[PAGE_SHIFT-1:0] == va_cap[PAGE_SHIFT-1:0]));

    // R4
    fetch_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));
endmodule

bind dvma_xlate dvma_xlate_chk #(
    .VA_W(VA_W), .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_fault(rsp_fault), .rsp_pa(rsp_pa), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr)
);

// File: tb/tb_dvma_xlate.sv
module tb_dvma_xlate;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_LAT    = 2;
    localparam int WD_CYCLES  = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [63:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic        rsp_fault;
    logic [40:0] rsp_pa;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [40:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    dvma_xlate dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .req_write(req_write), .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Table contents derived from the entry address.
    function automatic logic [63:0] ent_of(logic [40:0] a);
        logic [37:0] k;
        logic [27:0] ppn;
        logic v, w, f;
        k   = a[40:3];
        ppn = 28'(k * 38'd40503 + 38'h1234567);
        v   = (k[2:0] != 3'd5);
        w   = k[0];
        f   = k[3];
        return {v, 1'b0, f, f, f, 18'b0, ppn, 8'b0, f, 2'b0, w, 1'b0};
    endfunction

    logic        pend;
    int          cnt;
    logic [40:0] last_addr;
    int          nreads;

    always @(posedge clk) begin
        if (!rst_n) begin
            pend          <= 1'b0;
            cnt           <= 0;
            mem_rsp_valid <= 1'b0;
            mem_rsp_data  <= '0;
            mem_req_ready <= 1'b0;
            last_addr     <= '0;
            nreads        <= 0;
        end else begin
            mem_req_ready <= ~mem_req_ready;
            mem_rsp_valid <= 1'b0;
            if (mem_req_valid && mem_req_ready) begin
                pend      <= 1'b1;
                cnt       <= MEM_LAT;
                last_addr <= mem_req_addr;
                nreads    <= nreads + 1;
            end else if (pend) begin
                if (cnt == 0) begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_data  <= ent_of(last_addr);
                    pend          <= 1'b0;
                end else begin
                    cnt <= cnt - 1;
                end
            end
        end
    end

    // Reference state
    bit          m_en = 1'b0;
    int          m_code = 0;
    logic [40:0] m_base = '0;
    bit          mc_vld = 1'b0;
    logic [18:0] mc_vpn = '0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [1:0] a, input logic [63:0] d);
        @(negedge clk);
        cfg_addr  = a;
        cfg_wdata = d;
        cfg_we    = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a == 2'd0) begin
            m_en   = d[0];
            m_code = int'(d[18:16]);
        end
        if (a == 2'd1) m_base = {d[40:13], 13'b0};
        if (a != 2'd3) mc_vld = 1'b0;
    endtask

    task automatic xlate(input logic [31:0] va, input bit wr, input bit flush_mid,
                         input string tag);
        longint      win_lo;
        longint      slot;
        logic [40:0] exp_addr;
        logic [63:0] e;
        bit          exp_fault;
        logic [40:0] exp_pa;
        int          exp_reads;
        bit          hit;
        int          r0;
        int          guard;
        bit          fl_done;
        logic [40:0] pa_s;
        bit          flt_s;

        win_lo   = 64'h1_0000_0000 - (64'd1 << (23 + m_code));
        exp_addr = '0;
        if (!m_en || longint'(va) < win_lo) begin
            exp_fault = 1'b1;
            exp_pa    = '0;
            exp_reads = 0;
        end else begin
            slot      = (longint'(va) - win_lo) >> 13;
            exp_addr  = m_base + 41'(slot * 8);
            e         = ent_of(exp_addr);
            exp_fault = !e[63] || (wr && !e[1]);
            exp_pa    = exp_fault ? 41'd0 : {e[40:13], va[12:0]};
            hit       = mc_vld && (mc_vpn == va[31:13]);
            exp_reads = hit ? 0 : 1;
            if (!hit && e[63] && !flush_mid) begin
                mc_vld = 1'b1;
                mc_vpn = va[31:13];
            end
            if (flush_mid) mc_vld = 1'b0;
        end

        r0 = nreads;
        @(negedge clk);
        req_va    = va;
        req_write = wr;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, {tag, " R11 ready low after accept"}, req_ready, 0);
        guard   = 0;
        fl_done = 1'b0;
        while (!rsp_valid && guard < 100) begin
            if (cfg_we) cfg_we = 1'b0;
            if (flush_mid && !fl_done && mem_req_valid) begin
                cfg_addr = 2'd2;
                cfg_we   = 1'b1;
                fl_done  = 1'b1;
            end
            @(negedge clk);
            guard++;
        end
        cfg_we = 1'b0;
        chk(rsp_valid, {tag, " R11 response arrives"}, rsp_valid, 1);
        chk(rsp_fault == exp_fault, {tag, " fault"}, rsp_fault, exp_fault);
        chk(rsp_pa == exp_pa, {tag, " R7 physical address"}, rsp_pa, exp_pa);
        chk((nreads - r0) == exp_reads, {tag, " R8 table read count"}, nreads - r0, exp_reads);
        if (exp_reads == 1)
            chk(last_addr == exp_addr, {tag, " R4 fetch address"}, last_addr, exp_addr);
        pa_s  = rsp_pa;
        flt_s = rsp_fault;
        @(negedge clk);
        chk(rsp_valid && rsp_pa == pa_s && rsp_fault == flt_s,
            {tag, " R11 response held"}, rsp_pa, pa_s);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(req_ready && !rsp_valid, {tag, " R11 idle after handshake"}, req_ready, 1);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] lo;
        logic [31:0] pg_a;
        logic [31:0] pg_b;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 req_ready in reset", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", rsp_valid, 0);
        chk(mem_req_valid == 1'b0, "R1 mem_req_valid in reset", mem_req_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 req_ready after reset", req_ready, 1);

        // R2 disabled translation
        cfg_wr(2'd0, 64'h0007_0000);
        xlate(32'hFFFF_0000, 1'b0, 1'b0, "R2");
        xlate(32'hC000_0000, 1'b1, 1'b0, "R2");

        // R4 base with junk in low bits
        cfg_wr(2'd1, 64'hFF00_0123_4567_89AB);

        for (int n = 0; n < 8; n++) begin
            // R12 diag and page-size bits set on odd codes
            cfg_wr(2'd0, (64'(n) << 16) | 64'd1 | ((n % 2 == 1) ? 64'd6 : 64'd0));
            lo = 32'(64'h1_0000_0000 - (64'd1 << (23 + n)));
            xlate(lo - 32'd1, 1'b0, 1'b0, "R3 below window");
            xlate(lo, 1'b0, 1'b0, "R3 first slot");
            xlate(lo + 32'h1ABC, 1'b1, 1'b0, "R8 same page");
            xlate(lo + 32'h2000 * 5 + 32'h44, 1'b0, 1'b0, "R5 invalid entry");
            xlate(lo + 32'h2000 * 4 + 32'h10, 1'b1, 1'b0, "R6 write read-only");
            xlate(lo + 32'h2000 * 4 + 32'h18, 1'b0, 1'b0, "R6 read read-only");
            xlate(lo + 32'h2000 * 11 + 32'h7F8, 1'b1, 1'b0, "R12 flagged entry");
            xlate(32'hFFFF_FFFF, 1'b1, 1'b0, "R3 last slot");
        end

        // Cache behaviour at code 0
        cfg_wr(2'd0, 64'h0000_0001);
        pg_a = 32'hFF80_6010;
        pg_b = 32'hFF80_E020;
        xlate(pg_a, 1'b0, 1'b0, "R8 miss");
        xlate(pg_a + 32'h100, 1'b0, 1'b0, "R8 hit");
        cfg_wr(2'd2, 64'd0);
        xlate(pg_a, 1'b0, 1'b0, "R9 after flush");
        cfg_wr(2'd0, 64'h0000_0001);
        xlate(pg_a, 1'b0, 1'b0, "R9 after control write");
        cfg_wr(2'd1, 64'h0000_0123_4567_8000);
        xlate(pg_a, 1'b0, 1'b0, "R9 after base write");
        cfg_wr(2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
        xlate(pg_a, 1'b0, 1'b0, "R9 address 3 ignored");
        xlate(pg_b, 1'b0, 1'b0, "R8 evict");
        xlate(pg_a, 1'b0, 1'b0, "R8 refetch after evict");
        xlate(32'hFF80_A000, 1'b0, 1'b0, "R5 invalid first");
        xlate(32'hFF80_A008, 1'b0, 1'b0, "R5 invalid not cached");

        // R10 flush during outstanding fetch
        xlate(32'hFF81_2000, 1'b0, 1'b1, "R10 flush mid fetch");
        xlate(32'hFF81_2040, 1'b0, 1'b0, "R10 refetch");

        // R2 disable again after valid use
        cfg_wr(2'd0, 64'h0000_0000);
        xlate(pg_b, 1'b0, 1'b0, "R2 disabled again");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule